// File: doc/BRIEF.md
# Ethernet Transmit Dual-Buffer Controller

This block is the transmit side of a small memory-mapped Ethernet MAC. The host fills one of two frame buffers with 32-bit word writes, sets that buffer's length, and then writes a command to the buffer's control word. A plain start command streams the stored bytes out on a byte-wide valid/ready interface that marks the final byte. A start combined with the program flag does not send anything. It loads the first six bytes of the buffer into the station address output instead.

Each buffer has its own length and control words. A single global interrupt-enable bit, which exists only in buffer 0's register set, gates the one-cycle completion pulse for both buffers. Software can detect completion either by polling the start bit, which clears itself when the command finishes, or by taking the interrupt. Preamble, FCS, PHY signalling and collision handling belong to the stage that follows this block.

Top module: `eth_txb_ctrl`

## Requirements
- R1: The address map places buffer b at byte offset b*0x800. Within a buffer, the length word sits at +0x7F4 and the control word at +0x7FC, and words +0x000 to +0x7F0 hold frame data. Only whole 32-bit words are accessed, and address bits [1:0] are ignored. Read data appears on `bus_rdata` one cycle after `bus_rd`. The length word keeps its low 16 bits and reads back zero-extended.
- R2: In the control word, bit 0 is start, bit 1 is program and bit 3 is interrupt enable. A read returns these three bits in those positions with every other bit 0. The program bit is only taken when start is written as 1.
- R3: A start written with program clear sends the buffer's first `length` bytes in ascending address order, with the least significant byte of each word first. `tx_last` is high only on the final byte. While `tx_ready` is low, `tx_valid` and `tx_last` hold.
- R4: A start written with program set copies buffer byte k into `mac_addr[8k+7:8k]` for k = 0..5 and sends no bytes.
- R5: Start and program return to 0 when the command finishes. The interrupt-enable bit keeps its written value.
- R6: When a command finishes, `irq` is high for exactly one cycle if both of these hold: the buffer's interrupt-enable bit is set, and bit 31 of the global word at 0x7F8 is set. Otherwise no pulse occurs.
- R7: A write to a control word whose start bit is still set is ignored completely. It starts nothing, and it changes neither the interrupt-enable bit nor `mac_addr`.
- R8: A length of 0 finishes the command without sending any byte, and the interrupt rule of R6 still applies.
- R9: A length larger than the data area (2036 bytes) is clamped, so exactly 2036 bytes are sent.
- R10: A command written to the other buffer while one is in progress stays pending with its start bit set. Its bytes follow after the current frame's last byte.
- R11: After reset, all control, length and global words read 0, `mac_addr` is 0, and `tx_valid` and `irq` are low.
- R12: Only bit 31 of the global word is stored, so it reads back as 0x80000000 or 0. Buffer 1's matching offset (0xFF8) reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| mac_addr | output | 48 | Station address, byte 0 in bits [7:0] |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- `irq` is never wider than one cycle and never fires without the global enable.
- The stream holds under back-pressure.
- A handshaken last byte ends the stream.
- No byte is offered while no command is pending.

Some behaviour depends on content and order, and only the directed scenarios can show it:
- byte order and values;
- clamping of the length;
- the address copy;
- a control write being ignored while its buffer is busy;
- the pending command on the other buffer running in sequence.

// File: rtl/eth_txb_pkg.sv
// Shared types and field positions for the transmit dual-buffer controller.
// Assumes a 32-bit word bus; positions here are decoded by host software.
package eth_txb_pkg;
    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_PROG_BIT  = 1;
    localparam int CTRL_IE_BIT    = 3;
    localparam int GIE_BIT        = 31;

    // Register words counted back from the end of each buffer window
    localparam int LEN_FROM_END  = 3;
    localparam int GIE_FROM_END  = 2;
    localparam int CTRL_FROM_END = 1;

    typedef enum logic [1:0] {
        ACC_DATA,
        ACC_LEN,
        ACC_GIE,
        ACC_CTRL
    } acc_kind_e;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SEND,
        ENG_MAC_LO,
        ENG_MAC_HI,
        ENG_FINISH
    } eng_state_e;
endpackage

// File: rtl/eth_txb_store.sv
// Frame data storage for all buffers: one write port, two asynchronous
// read ports (host readback and the transmit engine).
// Assumes NUM_BUF and BUF_WORDS are powers of two so {buffer, word} indexes.
module eth_txb_store #(
    parameter int NUM_BUF   = 2,
    parameter int BUF_WORDS = 512,
    localparam int BUF_AW   = $clog2(NUM_BUF),
    localparam int WORD_AW  = $clog2(BUF_WORDS)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [BUF_AW-1:0]  wr_buf,
    input  logic [WORD_AW-1:0] wr_word,
    input  logic [31:0]        wr_data,
    input  logic [BUF_AW-1:0]  rda_buf,
    input  logic [WORD_AW-1:0] rda_word,
    output logic [31:0]        rda_data,
    input  logic [BUF_AW-1:0]  rdb_buf,
    input  logic [WORD_AW-1:0] rdb_word,
    output logic [31:0]        rdb_data
);
    localparam int DEPTH = NUM_BUF * BUF_WORDS;

    logic [31:0] mem [DEPTH];

    // Store host data words
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_buf, wr_word}] <= wr_data;
        end
    end

    // Readback for the host and fetch for the engine
    always_comb begin
        rda_data = mem[{rda_buf, rda_word}];
        rdb_data = mem[{rdb_buf, rdb_word}];
    end
endmodule

// File: rtl/eth_txb_regs.sv
// Per-buffer length and control words plus the single global interrupt
// enable. Control writes are dropped while that buffer's start bit is set;
// start and program clear when the engine reports completion.
module eth_txb_regs
    import eth_txb_pkg::*;
#(
    parameter int NUM_BUF = 2,
    parameter int LEN_W   = 16,
    localparam int BUF_AW = $clog2(NUM_BUF)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [BUF_AW-1:0]               wr_buf,
    input  acc_kind_e                       wr_kind,
    input  logic [31:0]                     wr_data,
    input  logic                            done,
    input  logic [BUF_AW-1:0]               done_buf,
    output logic [NUM_BUF-1:0][LEN_W-1:0]   len_q,
    output logic [NUM_BUF-1:0]              start_q,
    output logic [NUM_BUF-1:0]              prog_q,
    output logic [NUM_BUF-1:0]              ie_q,
    output logic                            gie_q
);
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        logic hit;
        assign hit = wr_en && (wr_buf == BUF_AW'(b));

        // Control word: command latch, self-clear on completion
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[b] <= 1'b0;
                prog_q[b]  <= 1'b0;
                ie_q[b]    <= 1'b0;
            end else begin
                if (done && (done_buf == BUF_AW'(b))) begin
                    start_q[b] <= 1'b0;
                    prog_q[b]  <= 1'b0;
                end
                if (hit && (wr_kind == ACC_CTRL) && !start_q[b]) begin
                    ie_q[b] <= wr_data[CTRL_IE_BIT];
                    if (wr_data[CTRL_START_BIT]) begin
                        start_q[b] <= 1'b1;
                        prog_q[b]  <= wr_data[CTRL_PROG_BIT];
                    end
                end
            end
        end

        // Length word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[b] <= '0;
            end else if (hit && (wr_kind == ACC_LEN)) begin
                len_q[b] <= wr_data[LEN_W-1:0];
            end
        end
    end

    // Global interrupt enable, present only in buffer 0's window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (wr_en && (wr_buf == '0) && (wr_kind == ACC_GIE)) begin
            gie_q <= wr_data[GIE_BIT];
        end
    end
endmodule

// File: rtl/eth_txb_engine.sv
// Command engine: picks the lowest-numbered buffer with start set, then
// streams its bytes (little-endian within each word) or loads the station
// address from its first six bytes, then raises completion and the
// gated interrupt pulse. Assumes LEN_W is wide enough to hold DATA_BYTES.
module eth_txb_engine
    import eth_txb_pkg::*;
#(
    parameter int NUM_BUF    = 2,
    parameter int BUF_WORDS  = 512,
    parameter int LEN_W      = 16,
    localparam int BUF_AW    = $clog2(NUM_BUF),
    localparam int WORD_AW   = $clog2(BUF_WORDS),
    localparam int DATA_BYTES = (BUF_WORDS - LEN_FROM_END) * 4,
    localparam int CNT_W     = $clog2(DATA_BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BUF-1:0]            start_q,
    input  logic [NUM_BUF-1:0]            prog_q,
    input  logic [NUM_BUF-1:0]            ie_q,
    input  logic                          gie_q,
    input  logic [NUM_BUF-1:0][LEN_W-1:0] len_q,
    output logic [BUF_AW-1:0]             rd_buf,
    output logic [WORD_AW-1:0]            rd_word,
    input  logic [31:0]                   rd_data,
    output logic                          tx_valid,
    input  logic                          tx_ready,
    output logic [7:0]                    tx_data,
    output logic                          tx_last,
    output logic [47:0]                   mac_addr,
    output logic                          irq,
    output logic                          done,
    output logic [BUF_AW-1:0]             done_buf
);
    eng_state_e        state;
    logic [BUF_AW-1:0] cur;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [31:0]       mac_lo;

    logic              pend_any;
    logic [BUF_AW-1:0] pend_idx;
    logic [LEN_W-1:0]  len_sel;
    logic [CNT_W-1:0]  len_eff;

    // Lowest-numbered pending buffer wins
    always_comb begin
        pend_any = 1'b0;
        pend_idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (start_q[i]) begin
                pend_any = 1'b1;
                pend_idx = BUF_AW'(i);
            end
        end
    end

    // Clamp the requested length to the data area
    always_comb begin
        len_sel = len_q[pend_idx];
        if (32'(len_sel) > 32'(DATA_BYTES)) begin
            len_eff = CNT_W'(DATA_BYTES);
        end else begin
            len_eff = CNT_W'(len_sel);
        end
    end

    // Storage fetch address and stream outputs
    always_comb begin
        rd_buf = cur;
        case (state)
            ENG_MAC_LO: rd_word = WORD_AW'(0);
            ENG_MAC_HI: rd_word = WORD_AW'(1);
            default:    rd_word = WORD_AW'(cnt >> 2);
        endcase
        tx_valid = (state == ENG_SEND);
        tx_data  = rd_data[{cnt[1:0], 3'b000} +: 8];
        tx_last  = (state == ENG_SEND) && (cnt == last_idx);
        done     = (state == ENG_FINISH);
        done_buf = cur;
    end

    // Command sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            cur      <= '0;
            cnt      <= '0;
            last_idx <= '0;
            mac_lo   <= '0;
            mac_addr <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (pend_any) begin
                        cur <= pend_idx;
                        cnt <= '0;
                        if (prog_q[pend_idx]) begin
                            state <= ENG_MAC_LO;
                        end else if (len_eff == '0) begin
                            state <= ENG_FINISH;
                        end else begin
                            last_idx <= len_eff - CNT_W'(1);
                            state    <= ENG_SEND;
                        end
                    end
                end
                ENG_SEND: begin
                    if (tx_ready) begin
                        if (tx_last) begin
                            state <= ENG_FINISH;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ENG_MAC_LO: begin
                    mac_lo <= rd_data;
                    state  <= ENG_MAC_HI;
                end
                ENG_MAC_HI: begin
                    mac_addr <= {rd_data[15:0], mac_lo};
                    state    <= ENG_FINISH;
                end
                default: begin
                    state <= ENG_IDLE;
                end
            endcase
        end
    end

    // Completion interrupt, gated by buffer and global enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (state == ENG_FINISH) && ie_q[cur] && gie_q;
        end
    end
endmodule

// File: rtl/eth_txb_ctrl.sv
// Top of the transmit dual-buffer controller: decodes the word bus into
// data, length, global-enable and control accesses, registers readback,
// and ties storage, register set and engine together.
// Assumes BUF_BYTES and NUM_BUF are powers of two, NUM_BUF >= 2.
module eth_txb_ctrl
    import eth_txb_pkg::*;
#(
    parameter int NUM_BUF   = 2,
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int BUF_AW    = $clog2(NUM_BUF),
    localparam int WORD_AW   = $clog2(BUF_WORDS),
    localparam int ADDR_W    = BUF_AW + WORD_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [47:0]       mac_addr,
    output logic              irq
);
    logic [BUF_AW-1:0]             acc_buf;
    logic [WORD_AW-1:0]            acc_word;
    acc_kind_e                     acc_kind;
    logic [31:0]                   store_rd;
    logic [BUF_AW-1:0]             eng_buf;
    logic [WORD_AW-1:0]            eng_word;
    logic [31:0]                   eng_data;
    logic [NUM_BUF-1:0][LEN_W-1:0] len_q;
    logic [NUM_BUF-1:0]            start_q;
    logic [NUM_BUF-1:0]            prog_q;
    logic [NUM_BUF-1:0]            ie_q;
    logic                          gie_q;
    logic                          done;
    logic [BUF_AW-1:0]             done_buf;

    // Split the byte address into buffer, word and access kind
    always_comb begin
        acc_buf  = bus_addr[ADDR_W-1 -: BUF_AW];
        acc_word = bus_addr[WORD_AW+1:2];
        if (acc_word == WORD_AW'(BUF_WORDS - LEN_FROM_END)) begin
            acc_kind = ACC_LEN;
        end else if (acc_word == WORD_AW'(BUF_WORDS - GIE_FROM_END)) begin
            acc_kind = ACC_GIE;
        end else if (acc_word == WORD_AW'(BUF_WORDS - CTRL_FROM_END)) begin
            acc_kind = ACC_CTRL;
        end else begin
            acc_kind = ACC_DATA;
        end
    end

    eth_txb_store #(
        .NUM_BUF  (NUM_BUF),
        .BUF_WORDS(BUF_WORDS)
    ) u_store (
        .clk     (clk),
        .wr_en   (bus_wr && (acc_kind == ACC_DATA)),
        .wr_buf  (acc_buf),
        .wr_word (acc_word),
        .wr_data (bus_wdata),
        .rda_buf (acc_buf),
        .rda_word(acc_word),
        .rda_data(store_rd),
        .rdb_buf (eng_buf),
        .rdb_word(eng_word),
        .rdb_data(eng_data)
    );

    eth_txb_regs #(
        .NUM_BUF(NUM_BUF),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_buf  (acc_buf),
        .wr_kind (acc_kind),
        .wr_data (bus_wdata),
        .done    (done),
        .done_buf(done_buf),
        .len_q   (len_q),
        .start_q (start_q),
        .prog_q  (prog_q),
        .ie_q    (ie_q),
        .gie_q   (gie_q)
    );

    eth_txb_engine #(
        .NUM_BUF  (NUM_BUF),
        .BUF_WORDS(BUF_WORDS),
        .LEN_W    (LEN_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_q (start_q),
        .prog_q  (prog_q),
        .ie_q    (ie_q),
        .gie_q   (gie_q),
        .len_q   (len_q),
        .rd_buf  (eng_buf),
        .rd_word (eng_word),
        .rd_data (eng_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .tx_data (tx_data),
        .tx_last (tx_last),
        .mac_addr(mac_addr),
        .irq     (irq),
        .done    (done),
        .done_buf(done_buf)
    );

    // Registered host readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (acc_kind)
                ACC_LEN:  bus_rdata <= 32'(len_q[acc_buf]);
                ACC_GIE:  bus_rdata <= (acc_buf == '0) ? {gie_q, 31'b0} : 32'b0;
                ACC_CTRL: bus_rdata <= {28'b0, ie_q[acc_buf], 1'b0,
                                        prog_q[acc_buf], start_q[acc_buf]};
                default:  bus_rdata <= store_rd;
            endcase
        end
    end
endmodule

// File: rtl/eth_txb_checker.sv
// Cycle-level properties of the transmit controller, bound to its top.
// Assumes the host does not rewrite a buffer's data while it is sending.
module eth_txb_checker #(
    parameter int NUM_BUF = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic               tx_last,
    input logic               irq,
    input logic               gie_q,
    input logic [NUM_BUF-1:0] start_q
);
    // R6: completion pulse lasts one cycle
    a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: no pulse unless the global enable was set
    a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gie_q));

    // R3: an offered byte holds under back-pressure
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_last)));

    // R3: the accepted last byte ends the stream
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    // R10: bytes only flow while some command is pending
    a_r10_stream_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (start_q != '0));
endmodule

bind eth_txb_ctrl eth_txb_checker #(.NUM_BUF(NUM_BUF)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_last (tx_last),
    .irq     (irq),
    .gie_q   (gie_q),
    .start_q (start_q)
);

// File: tb/eth_txb_ctrl_bench.sv
// Directed bench for the transmit dual-buffer controller.
module eth_txb_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic [47:0] mac_addr;
    logic        irq;

    int n_cmp = 0;
    int n_err = 0;
    int ready_mode = 0;   // 0 always ready, 1 stalled, 2 pattern
    int cyc = 0;
    logic [7:0] cap [4096];
    int cap_n = 0;
    int last_pos = -1;
    int last_cnt = 0;
    int irq_n = 0;

    eth_txb_ctrl u_eth_txb_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .mac_addr(mac_addr), .irq(irq)
    );

    always #2 clk = ~clk;

    // Drive downstream ready just after each edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (ready_mode)
            0:       tx_ready = 1'b1;
            1:       tx_ready = 1'b0;
            default: tx_ready = (cyc % 3) != 0;
        endcase
    end

    // Capture handshaken bytes and interrupt cycles mid-cycle
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            cap[cap_n] = tx_data;
            if (tx_last) begin
                last_pos = cap_n;
                last_cnt++;
            end
            cap_n++;
        end
        if (rst_n && irq) irq_n++;
    end

    function automatic logic [7:0] pat(int b, int a);
        return 8'((a * 13 + b * 101 + (a >> 6)) & 255);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fill(int b, int nwords);
        for (int w = 0; w < nwords; w++) begin
            wr(12'(b * 2048 + w * 4), {pat(b, 4*w+3), pat(b, 4*w+2),
                                       pat(b, 4*w+1), pat(b, 4*w)});
        end
    endtask

    task automatic wait_idle(int b);
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            rd(12'(b * 2048 + 12'h7FC), d);
            if (d[0] == 1'b0) break;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic clear_caps();
        cap_n = 0; last_pos = -1; last_cnt = 0; irq_n = 0;
    endtask

    // R11: state after reset
    task automatic t_reset();
        logic [31:0] d;
        rd(12'h7FC, d); chk("R11 ctrl0", d, 0);
        rd(12'hFFC, d); chk("R11 ctrl1", d, 0);
        rd(12'h7F4, d); chk("R11 len0", d, 0);
        rd(12'h7F8, d); chk("R11 gie", d, 0);
        chk("R11 mac", mac_addr, 0);
        chk("R11 tx_valid", tx_valid, 0);
        chk("R11 irq", irq, 0);
    endtask

    // R1, R2, R12: register and data readback
    task automatic t_regs();
        logic [31:0] d;
        wr(12'h7F4, 32'hABCD1234); rd(12'h7F4, d); chk("R1 len width", d, 32'h1234);
        wr(12'h816, 32'hCAFEF00D); rd(12'h814, d); chk("R1 data word", d, 32'hCAFEF00D);
        wr(12'h7F8, 32'hFFFFFFFF); rd(12'h7F8, d); chk("R12 gie bit", d, 32'h80000000);
        wr(12'hFF8, 32'h00000000); rd(12'h7F8, d); chk("R12 buf1 gie ignored", d, 32'h80000000);
        rd(12'hFF8, d); chk("R12 buf1 gie reads 0", d, 0);
        wr(12'h7FC, 32'hFFFFFFFC); rd(12'h7FC, d); chk("R2 ctrl fields", d, 32'h8);
        wr(12'h7FC, 32'h00000002); rd(12'h7FC, d); chk("R2 prog needs start", d, 0);
        chk("R2 no stream", tx_valid, 0);
        wr(12'h7F8, 32'h0);
    endtask

    // R3, R5, R6, R8, R9: one transmit command
    task automatic t_frame(string req, int b, int len, int mode, bit ie, bit gie);
        logic [31:0] d;
        int exp_len, nw, bad;
        exp_len = (len > 2036) ? 2036 : len;
        nw = (exp_len + 3) / 4;
        fill(b, nw);
        wr(12'(b * 2048 + 12'h7F4), 32'(len));
        wr(12'h7F8, gie ? 32'h80000000 : 32'h0);
        ready_mode = mode;
        clear_caps();
        wr(12'(b * 2048 + 12'h7FC), {28'b0, ie, 3'b001});
        wait_idle(b);
        ready_mode = 0;
        chk({req, " byte count"}, cap_n, exp_len);
        bad = 0;
        for (int k = 0; k < cap_n && k < exp_len; k++) begin
            if (cap[k] !== pat(b, k)) bad++;
        end
        chk({req, " R3 byte order"}, bad, 0);
        chk({req, " R3 last position"}, 64'(last_pos), 64'(exp_len - 1));
        chk({req, " R3 last count"}, last_cnt, exp_len > 0 ? 1 : 0);
        rd(12'(b * 2048 + 12'h7FC), d);
        chk({req, " R5 ctrl after"}, d, {28'b0, ie, 3'b000});
        chk({req, " R6 irq pulses"}, irq_n, (ie && gie) ? 1 : 0);
    endtask

    // R4: address load
    task automatic t_mac();
        logic [31:0] d;
        wr(12'h800, 32'h44332211);
        wr(12'h804, 32'hDEAD6655);
        wr(12'h7F8, 32'h80000000);
        clear_caps();
        wr(12'hFFC, 32'h0000000B);
        wait_idle(1);
        chk("R4 mac value", mac_addr, 48'h665544332211);
        chk("R4 no bytes", cap_n, 0);
        chk("R6 mac irq", irq_n, 1);
        rd(12'hFFC, d); chk("R5 mac ctrl after", d, 32'h8);
    endtask

    // R7, R10: busy writes ignored, other buffer waits its turn
    task automatic t_busy();
        logic [31:0] d;
        logic [47:0] mac_before;
        int bad;
        mac_before = mac_addr;
        fill(0, 1); fill(1, 1);
        wr(12'h7F4, 32'd4); wr(12'hFF4, 32'd3);
        wr(12'h7F8, 32'h80000000);
        ready_mode = 1;
        clear_caps();
        wr(12'h7FC, 32'h1);
        repeat (3) @(posedge clk);
        #1;
        wr(12'h7FC, 32'hB);
        rd(12'h7FC, d); chk("R7 busy ctrl unchanged", d, 32'h1);
        wr(12'hFFC, 32'h1);
        rd(12'hFFC, d); chk("R10 other pending", d, 32'h1);
        chk("R7 stalled", cap_n, 0);
        ready_mode = 0;
        wait_idle(0); wait_idle(1);
        chk("R10 total bytes", cap_n, 7);
        bad = 0;
        for (int k = 0; k < 7; k++) begin
            if (cap[k] !== ((k < 4) ? pat(0, k) : pat(1, k - 4))) bad++;
        end
        chk("R10 order", bad, 0);
        chk("R7 mac untouched", mac_addr, mac_before);
        chk("R7 no irq", irq_n, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_regs();
        t_frame("R3 pattern", 0, 5, 2, 1'b1, 1'b1);
        t_frame("R6 gie off", 1, 13, 0, 1'b1, 1'b0);
        t_frame("R6 ie off", 0, 8, 0, 1'b0, 1'b1);
        t_frame("R8 zero length", 1, 0, 0, 1'b1, 1'b1);
        t_frame("R9 clamp", 1, 32'hFFFF, 2, 1'b0, 1'b1);
        t_mac();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_cmp++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule